// File: doc/BRIEF.md
# Point-Cloud Phase Hologram Row Engine

This block computes one row of a point-cloud phase hologram. A host loads up to a fixed number of object points into on-chip RAM. Each point is a column coordinate, a row coordinate and a depth coefficient `rho` that the host computes in advance, so the block holds no divider. The host then sets the row geometry (leftmost column `x0`, row coordinate `y`) and the number of points, and pulses `start`. The points stream from the RAM one per clock into a chain of pixel units, one unit for each column of the row.

A head stage works out, for each point, the exact phase at the leftmost column, the first increment and the constant second difference. Every pixel unit after it gets its phase by adding the increment it receives, and gets its increment by adding the second difference, so there is no multiplier per column. Each unit turns its phase into cosine and sine through small tables and keeps a signed running sum of each over all points of the run. The sums form the complex field of the row. When the last point has passed through the chain, `done` rises and the sums stay stable for the host to read.

Phase is an unsigned fraction of one cycle, so wraparound comes free from the modular adder. The top six phase bits address the trig tables.

Top module: `hre_line_engine`

## Requirements
- R1: Pixel column n (0 to NPIX-1) uses the phase `rho * ((x0 + n - xj)^2 + (y - yj)^2) mod 2^PW`. The phase is in units of 2^-PW of a cycle. `x0`, `y`, `xj` and `yj` are CW-bit two's complement, and `rho` is PW-bit unsigned. The top 6 phase bits form the table address `a`.
- R2: The sine table gives the signed 6-bit value round(31*sin(2*pi*a/64)). The cosine value is the sine entry at address (a+16) mod 64.
- R3: At the end of a run, the `acc_re` field of column n at bits [n*ACCW +: ACCW] holds the two's complement sum of the cosine values over the run's points, and `acc_im` holds the sum of the sine values. Both sums are cleared when a run is launched.
- R4: A run uses the points at RAM addresses 0 to npts-1, where npts is `cfg_npts` clamped to MAXPTS.
- R5: A run with zero points ends with `done` high and every sum zero.
- R6: `done` rises only after the last point has been added into every column, and `busy` falls at the same edge. `done` and all sums then hold until the next launch.
- R7: A write to the point RAM while `busy` is high is ignored.
- R8: `cfg_npts`, `cfg_x0` and `cfg_row_y` are sampled only at launch. Changing them during a run has no effect.
- R9: A `start` pulse while `busy` is high is ignored, and the run in progress continues.
- R10: After reset, `busy` and `done` are low and all sums are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pt_we | input | 1 | Point RAM write enable |
| pt_addr | input | AW | Point RAM write address |
| pt_x | input | CW | Point column coordinate, signed |
| pt_y | input | CW | Point row coordinate, signed |
| pt_rho | input | PW | Point depth coefficient, unsigned phase units |
| cfg_npts | input | NCW | Number of points to use in the run |
| cfg_x0 | input | CW | Leftmost column coordinate of the row, signed |
| cfg_row_y | input | CW | Row coordinate, signed |
| start | input | 1 | Launches a run when idle |
| busy | output | 1 | A run is in progress |
| done | output | 1 | The last run has finished and its sums are valid |
| acc_re | output | NPIX*ACCW | Per-column real sums, column n at [n*ACCW +: ACCW] |
| acc_im | output | NPIX*ACCW | Per-column imaginary sums, same layout |

## Verification
The hardest case to reach from the ports is a change to the RAM, the configuration or `start` while points are still in flight. Such a change has no visible effect until a later run reads the same addresses. The bench launches a run, waits a few cycles, then overwrites address 0, changes every configuration input and pulses `start`. It checks that run against the original model, then runs again and checks that the old point is still in RAM. The wraparound of the recurrence is reached with large `rho` values and coordinates spread across both signs. Any error of one LSB in the chain then moves a table address in some column.

// File: rtl/hre_pkg.sv
package hre_pkg;

  // Trig table address and output widths. The quarter-wave table below
  // is written for exactly this size.
  localparam int TRIG_AW = 6;
  localparam int TRIG_DW = 6;

  // First quadrant magnitudes: round(31*sin(2*pi*k/64)), k = 0..16
  function automatic logic [4:0] quarter_mag(input logic [4:0] k);
    case (k)
      5'd0:  quarter_mag = 5'd0;
      5'd1:  quarter_mag = 5'd3;
      5'd2:  quarter_mag = 5'd6;
      5'd3:  quarter_mag = 5'd9;
      5'd4:  quarter_mag = 5'd12;
      5'd5:  quarter_mag = 5'd15;
      5'd6:  quarter_mag = 5'd17;
      5'd7:  quarter_mag = 5'd20;
      5'd8:  quarter_mag = 5'd22;
      5'd9:  quarter_mag = 5'd24;
      5'd10: quarter_mag = 5'd26;
      5'd11: quarter_mag = 5'd27;
      5'd12: quarter_mag = 5'd29;
      5'd13: quarter_mag = 5'd30;
      5'd14: quarter_mag = 5'd30;
      5'd15: quarter_mag = 5'd31;
      default: quarter_mag = 5'd31;
    endcase
  endfunction

  function automatic logic signed [TRIG_DW-1:0] wave_sin(input logic [TRIG_AW-1:0] a);
    logic [4:0] k;
    logic [4:0] m;
    k = a[4] ? (5'd16 - {1'b0, a[3:0]}) : {1'b0, a[3:0]};
    m = quarter_mag(k);
    wave_sin = a[5] ? -$signed({1'b0, m}) : $signed({1'b0, m});
  endfunction

  function automatic logic signed [TRIG_DW-1:0] wave_cos(input logic [TRIG_AW-1:0] a);
    wave_cos = wave_sin(a + 6'd16);
  endfunction

endpackage

// File: rtl/hre_point_ram.sv
module hre_point_ram #(
  parameter int DEPTH = 64,
  parameter int DW    = 40,
  parameter int AW    = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic          re,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);

  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (re) rdata <= mem[raddr];
  end

endmodule

// File: rtl/hre_seq.sv
module hre_seq #(
  parameter int MAXPTS = 64,
  parameter int CW     = 12,
  parameter int AW     = $clog2(MAXPTS),
  parameter int NCW    = $clog2(MAXPTS + 1)
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           start,
  input  logic [NCW-1:0] cfg_npts,
  input  logic [CW-1:0]  cfg_x0,
  input  logic [CW-1:0]  cfg_row_y,
  input  logic           pipe_busy,
  output logic           launch,
  output logic           rd_en,
  output logic [AW-1:0]  rd_addr,
  output logic           rd_valid,
  output logic           busy,
  output logic           done,
  output logic [CW-1:0]  x0_q,
  output logic [CW-1:0]  y_q
);

  localparam logic [NCW-1:0] CAP = NCW'(MAXPTS);

  logic [NCW-1:0] cnt;
  logic [NCW-1:0] lim;

  assign launch  = start && !busy;
  assign rd_en   = busy && (cnt < lim);
  assign rd_addr = cnt[AW-1:0];

  always_ff @(posedge clk) begin
    if (rst) begin
      busy     <= 1'b0;
      done     <= 1'b0;
      cnt      <= '0;
      lim      <= '0;
      rd_valid <= 1'b0;
      x0_q     <= '0;
      y_q      <= '0;
    end else begin
      rd_valid <= rd_en;
      if (launch) begin
        busy <= 1'b1;
        done <= 1'b0;
        cnt  <= '0;
        lim  <= (cfg_npts > CAP) ? CAP : cfg_npts;
        x0_q <= cfg_x0;
        y_q  <= cfg_row_y;
      end else if (busy) begin
        if (rd_en) begin
          cnt <= cnt + 1'b1;
        end else if (!rd_valid && !pipe_busy) begin
          busy <= 1'b0;
          done <= 1'b1;
        end
      end
    end
  end

endmodule

// File: rtl/hre_head.sv
module hre_head #(
  parameter int CW = 12,
  parameter int PW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          in_v,
  input  logic [CW-1:0] x0,
  input  logic [CW-1:0] y,
  input  logic [CW-1:0] px,
  input  logic [CW-1:0] py,
  input  logic [PW-1:0] rho,
  output logic          out_v,
  output logic [PW-1:0] out_ph,
  output logic [PW-1:0] out_dl,
  output logic [PW-1:0] out_gm,
  output logic          stage_busy
);

  // Offsets reduced modulo 2^PW; squares and products stay exact mod 2^PW.
  logic [PW-1:0] dxm, dym;
  always_comb begin
    dxm = PW'($signed(x0)) - PW'($signed(px));
    dym = PW'($signed(y))  - PW'($signed(py));
  end

  // Stage A: squared distance and linear term
  logic          v_a;
  logic [PW-1:0] sq_a, lin_a, rho_a;

  always_ff @(posedge clk) begin
    if (rst) v_a <= 1'b0;
    else     v_a <= in_v;
    sq_a  <= dxm * dxm + dym * dym;
    lin_a <= {dxm[PW-2:0], 1'b1};
    rho_a <= rho;
  end

  // Stage B: scale by rho
  always_ff @(posedge clk) begin
    if (rst) out_v <= 1'b0;
    else     out_v <= v_a;
    out_ph <= sq_a * rho_a;
    out_dl <= lin_a * rho_a;
    out_gm <= {rho_a[PW-2:0], 1'b0};
  end

  assign stage_busy = v_a || out_v;

endmodule

// File: rtl/hre_pixel.sv
module hre_pixel import hre_pkg::*; #(
  parameter int PW      = 16,
  parameter int ACCW    = 13,
  parameter bit ADVANCE = 1'b1
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   clr,
  input  logic                   in_v,
  input  logic [PW-1:0]          in_ph,
  input  logic [PW-1:0]          in_dl,
  input  logic [PW-1:0]          in_gm,
  output logic                   out_v,
  output logic [PW-1:0]          out_ph,
  output logic [PW-1:0]          out_dl,
  output logic [PW-1:0]          out_gm,
  output logic signed [ACCW-1:0] acc_re,
  output logic signed [ACCW-1:0] acc_im
);

  logic [PW-1:0] nxt_ph, nxt_dl;

  generate
    if (ADVANCE) begin : g_step
      always_comb begin
        nxt_ph = in_ph + in_dl;
        nxt_dl = in_dl + in_gm;
      end
    end else begin : g_pass
      always_comb begin
        nxt_ph = in_ph;
        nxt_dl = in_dl;
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) out_v <= 1'b0;
    else     out_v <= in_v;
    out_ph <= nxt_ph;
    out_dl <= nxt_dl;
    out_gm <= in_gm;
  end

  logic [TRIG_AW-1:0] taddr;
  assign taddr = out_ph[PW-1 -: TRIG_AW];

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      acc_re <= '0;
      acc_im <= '0;
    end else if (out_v) begin
      acc_re <= acc_re + ACCW'(wave_cos(taddr));
      acc_im <= acc_im + ACCW'(wave_sin(taddr));
    end
  end

endmodule

// File: rtl/hre_line_engine.sv
module hre_line_engine import hre_pkg::*; #(
  parameter int NPIX   = 8,
  parameter int MAXPTS = 64,
  parameter int CW     = 12,
  parameter int PW     = 16,
  parameter int AW     = $clog2(MAXPTS),
  parameter int NCW    = $clog2(MAXPTS + 1),
  parameter int ACCW   = TRIG_DW + NCW
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 pt_we,
  input  logic [AW-1:0]        pt_addr,
  input  logic [CW-1:0]        pt_x,
  input  logic [CW-1:0]        pt_y,
  input  logic [PW-1:0]        pt_rho,
  input  logic [NCW-1:0]       cfg_npts,
  input  logic [CW-1:0]        cfg_x0,
  input  logic [CW-1:0]        cfg_row_y,
  input  logic                 start,
  output logic                 busy,
  output logic                 done,
  output logic [NPIX*ACCW-1:0] acc_re,
  output logic [NPIX*ACCW-1:0] acc_im
);

  localparam int DW = 2 * CW + PW;

  logic          launch, rd_en, rd_valid, pipe_busy, head_busy;
  logic [AW-1:0] rd_addr;
  logic [DW-1:0] rd_data;
  logic [CW-1:0] x0_q, y_q;

  hre_seq #(.MAXPTS(MAXPTS), .CW(CW), .AW(AW), .NCW(NCW)) u_seq (
    .clk(clk), .rst(rst), .start(start),
    .cfg_npts(cfg_npts), .cfg_x0(cfg_x0), .cfg_row_y(cfg_row_y),
    .pipe_busy(pipe_busy), .launch(launch),
    .rd_en(rd_en), .rd_addr(rd_addr), .rd_valid(rd_valid),
    .busy(busy), .done(done), .x0_q(x0_q), .y_q(y_q)
  );

  // Host writes are refused while a run reads the RAM.
  hre_point_ram #(.DEPTH(MAXPTS), .DW(DW), .AW(AW)) u_ram (
    .clk(clk), .we(pt_we && !busy), .waddr(pt_addr),
    .wdata({pt_x, pt_y, pt_rho}),
    .re(rd_en), .raddr(rd_addr), .rdata(rd_data)
  );

  logic          ch_v  [NPIX+1];
  logic [PW-1:0] ch_ph [NPIX+1];
  logic [PW-1:0] ch_dl [NPIX+1];
  logic [PW-1:0] ch_gm [NPIX+1];

  hre_head #(.CW(CW), .PW(PW)) u_head (
    .clk(clk), .rst(rst), .in_v(rd_valid),
    .x0(x0_q), .y(y_q),
    .px(rd_data[DW-1 -: CW]), .py(rd_data[PW +: CW]), .rho(rd_data[PW-1:0]),
    .out_v(ch_v[0]), .out_ph(ch_ph[0]), .out_dl(ch_dl[0]), .out_gm(ch_gm[0]),
    .stage_busy(head_busy)
  );

  logic [NPIX-1:0] pix_v;

  generate
    for (genvar n = 0; n < NPIX; n++) begin : g_pix
      logic signed [ACCW-1:0] re_n, im_n;
      hre_pixel #(.PW(PW), .ACCW(ACCW), .ADVANCE(n != 0)) u_pix (
        .clk(clk), .rst(rst), .clr(launch),
        .in_v(ch_v[n]), .in_ph(ch_ph[n]), .in_dl(ch_dl[n]), .in_gm(ch_gm[n]),
        .out_v(ch_v[n+1]), .out_ph(ch_ph[n+1]), .out_dl(ch_dl[n+1]), .out_gm(ch_gm[n+1]),
        .acc_re(re_n), .acc_im(im_n)
      );
      assign pix_v[n] = ch_v[n+1];
      assign acc_re[n*ACCW +: ACCW] = re_n;
      assign acc_im[n*ACCW +: ACCW] = im_n;
    end
  endgenerate

  assign pipe_busy = head_busy || (|pix_v);

endmodule

// File: rtl/hre_line_engine_chk.sv
module hre_line_engine_chk #(
  parameter int NPIX   = 8,
  parameter int MAXPTS = 64,
  parameter int ACCW   = 13
) (
  input logic                 clk,
  input logic                 rst,
  input logic                 start,
  input logic                 busy,
  input logic                 done,
  input logic [NPIX*ACCW-1:0] acc_re,
  input logic [NPIX*ACCW-1:0] acc_im
);

  localparam int BOUND = 31 * MAXPTS;

  // R6: a finished run is never also in progress
  a_r6_busy_done_exclusive: assert property (@(posedge clk) disable iff (rst)
    !(busy && done));

  // R6: done can only rise at the end of a run
  a_r6_done_after_busy: assert property (@(posedge clk) disable iff (rst)
    $rose(done) |-> $past(busy));

  // R6: sums hold while done and no new launch
  a_r6_hold_while_done: assert property (@(posedge clk) disable iff (rst)
    (done && !start) |=> ($stable(acc_re) && $stable(acc_im) && done));

  // R3: launching clears every sum
  a_r3_clear_on_launch: assert property (@(posedge clk) disable iff (rst)
    (start && !busy) |=> (acc_re == '0 && acc_im == '0));

  // R9: a start during a run does not clear the sums
  a_r9_no_restart: assert property (@(posedge clk) disable iff (rst)
    (start && busy) |=> busy || done);

  generate
    for (genvar n = 0; n < NPIX; n++) begin : g_bnd
      // R3: each sum stays within the range of MAXPTS table values
      a_r3_sum_bounded: assert property (@(posedge clk) disable iff (rst)
        ($signed(acc_re[n*ACCW +: ACCW]) <= BOUND) &&
        ($signed(acc_re[n*ACCW +: ACCW]) >= -BOUND) &&
        ($signed(acc_im[n*ACCW +: ACCW]) <= BOUND) &&
        ($signed(acc_im[n*ACCW +: ACCW]) >= -BOUND));
    end
  endgenerate

endmodule

bind hre_line_engine hre_line_engine_chk #(.NPIX(NPIX), .MAXPTS(MAXPTS), .ACCW(ACCW)) u_chk (
  .clk(clk), .rst(rst), .start(start), .busy(busy), .done(done),
  .acc_re(acc_re), .acc_im(acc_im)
);

// File: tb/hre_line_engine_bench.sv
module hre_line_engine_bench;

  localparam int NPIX   = 8;
  localparam int MAXPTS = 64;
  localparam int CW     = 12;
  localparam int PW     = 16;
  localparam int AW     = $clog2(MAXPTS);
  localparam int NCW    = $clog2(MAXPTS + 1);
  localparam int ACCW   = 6 + NCW;

  logic                 clk = 1'b0;
  logic                 rst = 1'b1;
  logic                 pt_we = 1'b0;
  logic [AW-1:0]        pt_addr = '0;
  logic [CW-1:0]        pt_x = '0, pt_y = '0;
  logic [PW-1:0]        pt_rho = '0;
  logic [NCW-1:0]       cfg_npts = '0;
  logic [CW-1:0]        cfg_x0 = '0, cfg_row_y = '0;
  logic                 start = 1'b0;
  logic                 busy, done;
  logic [NPIX*ACCW-1:0] acc_re, acc_im;

  always #2.5 clk = ~clk;

  hre_line_engine #(.NPIX(NPIX), .MAXPTS(MAXPTS), .CW(CW), .PW(PW)) u_hre_line_engine (
    .clk(clk), .rst(rst), .pt_we(pt_we), .pt_addr(pt_addr),
    .pt_x(pt_x), .pt_y(pt_y), .pt_rho(pt_rho),
    .cfg_npts(cfg_npts), .cfg_x0(cfg_x0), .cfg_row_y(cfg_row_y),
    .start(start), .busy(busy), .done(done), .acc_re(acc_re), .acc_im(acc_im)
  );

  int checks = 0;
  int fails  = 0;
  int mx [MAXPTS];
  int my [MAXPTS];
  int mr [MAXPTS];
  int unsigned seed = 32'h1234_5678;

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // R2: table value from the sine definition
  function automatic int lut6(input int a);
    real r;
    r = 31.0 * $sin(6.283185307179586 * real'(a) / 64.0);
    return int'(r);
  endfunction

  function automatic int rnd(input int span);
    seed = seed * 32'd1103515245 + 32'd12345;
    return int'((seed >> 8) % span);
  endfunction

  task automatic put_point(input int idx, input int x, input int y, input int rho);
    @(negedge clk);
    pt_we = 1'b1; pt_addr = AW'(idx);
    pt_x = CW'(x); pt_y = CW'(y); pt_rho = PW'(rho);
    @(negedge clk);
    pt_we = 1'b0;
    mx[idx] = x; my[idx] = y; mr[idx] = rho;
  endtask

  task automatic launch(input int x0, input int y, input int n);
    @(negedge clk);
    cfg_x0 = CW'(x0); cfg_row_y = CW'(y); cfg_npts = NCW'(n); start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic wait_done(input string req);
    int k;
    k = 0;
    while (!done && k < 2000) begin
      @(negedge clk);
      k++;
    end
    check(done == 1'b1, {req, " done reached"}, done, 1);
  endtask

  // R1 R3 R4: compare every column with a direct squared-distance model
  task automatic check_row(input string req, input int x0, input int y, input int n);
    int lim;
    lim = (n > MAXPTS) ? MAXPTS : n;
    for (int c = 0; c < NPIX; c++) begin
      int sre, sim;
      sre = 0; sim = 0;
      for (int j = 0; j < lim; j++) begin
        longint dx, dy, sq, ph;
        int a;
        dx = longint'(x0 + c - mx[j]);
        dy = longint'(y - my[j]);
        sq = dx * dx + dy * dy;
        ph = (longint'(mr[j]) * sq) & 64'hFFFF;
        a  = int'(ph >> 10);
        sre += lut6((a + 16) % 64);
        sim += lut6(a);
      end
      check(int'($signed(acc_re[c*ACCW +: ACCW])) == sre, {req, " re"},
            int'($signed(acc_re[c*ACCW +: ACCW])), sre);
      check(int'($signed(acc_im[c*ACCW +: ACCW])) == sim, {req, " im"},
            int'($signed(acc_im[c*ACCW +: ACCW])), sim);
    end
  endtask

  task automatic t_reset;
    check(busy == 1'b0, "R10 busy", busy, 0);
    check(done == 1'b0, "R10 done", done, 0);
    check(acc_re == '0 && acc_im == '0, "R10 sums zero", 0, 0);
  endtask

  task automatic t_basic;
    put_point(0, 3, -2, 16'h0800);
    put_point(1, -40, 17, 16'h1234);
    put_point(2, 100, 5, 16'h0031);
    put_point(3, 0, 0, 16'hFFFF);
    put_point(4, -2048, 2047, 16'h7A11);
    launch(-5, 2, 5);
    wait_done("R1 basic");
    check_row("R1 R3 basic row", -5, 2, 5);
    launch(1900, -700, 5);
    wait_done("R1 far row");
    check_row("R1 R3 far row wrap", 1900, -700, 5);
  endtask

  // R2: a single point with a phase that walks across table quadrants
  task automatic t_single;
    put_point(0, 0, 0, 16'h0400);
    launch(0, 0, 1);
    wait_done("R2 single");
    check_row("R2 single point quadrants", 0, 0, 1);
    put_point(0, 7, -3, 16'h9E37);
    launch(-1, 4, 1);
    wait_done("R2 large rho");
    check_row("R1 R2 large rho", -1, 4, 1);
  endtask

  task automatic t_zero;
    launch(10, 10, 0);
    wait_done("R5 zero");
    check(acc_re == '0 && acc_im == '0, "R5 zero-point sums", 0, 0);
    check(busy == 1'b0, "R5 busy low", busy, 0);
  endtask

  task automatic t_full;
    for (int j = 0; j < MAXPTS; j++)
      put_point(j, rnd(4096) - 2048, rnd(4096) - 2048, rnd(65536));
    launch(-300, 250, MAXPTS);
    wait_done("R4 full");
    check_row("R4 full RAM", -300, 250, MAXPTS);
    launch(12, -9, 100);
    wait_done("R4 clamp");
    check_row("R4 count clamped", 12, -9, 100);
    launch(12, -9, 3);
    wait_done("R4 short");
    check_row("R3 R4 short after long", 12, -9, 3);
  endtask

  // R6: done and sums hold until the next launch
  task automatic t_hold;
    logic [NPIX*ACCW-1:0] keep;
    keep = acc_re;
    repeat (6) @(negedge clk);
    check(done == 1'b1, "R6 done holds", done, 1);
    check(busy == 1'b0, "R6 busy low with done", busy, 0);
    check(acc_re == keep, "R6 sums stable", 0, 0);
  endtask

  // R7 R8 R9: writes, config changes and start during a run
  task automatic t_busy_ignore;
    launch(40, -20, 30);
    repeat (3) @(negedge clk);
    check(busy == 1'b1, "R8 busy during run", busy, 1);
    pt_we = 1'b1; pt_addr = '0; pt_x = CW'(555); pt_y = CW'(-555); pt_rho = 16'h4321;
    cfg_x0 = CW'(-999); cfg_row_y = CW'(333); cfg_npts = NCW'(2);
    @(negedge clk);
    pt_we = 1'b0;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    wait_done("R8 run");
    check_row("R8 R9 config and start ignored", 40, -20, 30);
    launch(40, -20, 30);
    wait_done("R7 rerun");
    check_row("R7 busy write ignored", 40, -20, 30);
  endtask

  bit finished = 1'b0;

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_basic();
    t_single();
    t_zero();
    t_full();
    t_hold();
    t_busy_ignore();
    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

endmodule